// File: doc/BRIEF.md
# Configuration Memory Readout Sequencer

This block is the read side of a configuration store that feeds an FPGA while it boots. A small internal byte array holds up to four design revisions. Each revision has its own start address and a fixed length. An address counter walks through the active revision and steps on edges of a selectable configuration clock. The current byte leaves the block either one bit at a time on pin 0 or a whole byte per address on all eight pins. Every pin has its own tristate enable.

Four conditions must hold together before the counter may step: the chip is enabled, the output-enable/reset line is high, the configuration-pulse line is high, and, in parallel mode only, the target is not busy. A rising edge on the configuration-pulse line samples the revision select and reloads the counter with that revision's start address. When the counter reaches the last address of the revision, it stops and a done flag rises.

The sequencer is a three-state machine. HOLD covers standby or reset: the counter sits at the revision start and every output is disabled. RUN is streaming. DONE means the end was reached and the outputs are frozen. The transitions are:
- hold-assert: from any state to HOLD, whenever the chip is disabled or output-enable/reset is low.
- release: from HOLD to RUN, once both lines are inactive.
- end-reached: from RUN to DONE, when a step arrives at the last address.
- reload: from RUN or DONE to RUN, on a configuration-pulse rising edge.

All external edges are seen through synchronizers in the `clk` domain.

Top module: `cfg_readout`

## Requirements
- R1: The counter steps only on a clock strobe while `ce_n`=0, `oe_rst_n`=1 and `cfg_pulse`=1. In parallel mode it also needs `busy`=0; in serial mode `busy` is ignored.
- R2: While `oe_rst_n`=0, from the next cycle `dout_oe`=0, `clkout_oe`=0 and `dout`=0, and the counter is held at the start address of the latched revision.
- R3: While `ce_n`=1 (standby), outputs and counter behave as in R2, and clock strobes have no effect.
- R4: A rising edge of `cfg_pulse` latches `rev_sel` and loads the counter with that revision's start address. The default starts are 0, 16, 32 and 48 for revisions 0 to 3. A reload wins over a step seen in the same cycle.
- R5: In serial mode (`par_mode`=0), `dout_oe`=8'h01. `dout[0]` presents the current byte MSB first, one bit per step, and the address advances after the 8th step. Pins 7..1 stay disabled.
- R6: In parallel mode (`par_mode`=1), `dout_oe`=8'hFF and `dout` carries the byte at the counter address. Each step advances the address by one.
- R7: Each revision spans 16 bytes. At the last address (start+15) a further step sets `done`=1, and later steps change nothing. A reload clears `done`.
- R8: With `clk_sel_int`=1, one-cycle `int_tick` strobes are the step clock and `cfg_clk` is ignored. With `clk_sel_int`=0, rising edges of `cfg_clk` step the counter. `clkout` follows the chosen source.
- R9: The byte stored at address a is ((a*29) mod 256) XOR 8'h5A.
- R10: After `rst_n` the latched revision is 0 and `done`=0. While `ce_n`=1, all outputs remain disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all logic and synchronizers run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | External configuration clock, synchronized |
| int_tick | input | 1 | One-cycle strobes from the internal clock source |
| clk_sel_int | input | 1 | 1 selects `int_tick`, 0 selects `cfg_clk` |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| oe_rst_n | input | 1 | Output enable / counter reset; low holds reset |
| busy | input | 1 | Target busy, honoured in parallel mode only |
| cfg_pulse | input | 1 | Configuration pulse; rising edge reloads the revision |
| rev_sel | input | 2 | Revision select, sampled on a `cfg_pulse` rise |
| par_mode | input | 1 | 1 parallel byte output, 0 serial on pin 0 |
| dout | output | 8 | Data pins |
| dout_oe | output | 8 | Per-pin tristate enables |
| clkout | output | 1 | Forwarded configuration clock |
| clkout_oe | output | 1 | Enable for `clkout` |
| done | output | 1 | End of revision reached |

## Verification
The bench reloads each revision and walks it for several step counts, including the last address and steps past it. A counter that overran would show a byte from the next revision, and one that stopped early would raise `done` one address short. It raises `cfg_clk` and `cfg_pulse` in the same cycle after the counter has moved: the byte must be the new start, not start+1, or the priority is inverted. It asserts `busy` in both modes and sends `cfg_clk` edges while the internal source is selected. A design that gated wrongly would move the address in those cases. It also reads a serial byte bit by bit, where an LSB-first or off-by-one shifter shows a wrong bit. Finally, it checks that standby and reset both tristate the outputs and rewind the counter.

// File: rtl/cfg_readout_pkg.sv
package cfg_readout_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // stored content: address times 29, low byte, xor 5A
    function automatic logic [BYTE_W-1:0] store_byte(input int unsigned a);
        int unsigned v;
        v = (a * 29) ^ 32'h5A;
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_readout_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    output logic [BYTE_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        rdata <= store_byte(int'(addr));
    end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_readout_pkg::*;
#(
    parameter int AW   = 6,
    parameter int NREV = 4,
    parameter int SPAN = 16,
    parameter logic [NREV*AW-1:0] REV_BASE = '0,
    localparam int RW  = $clog2(NREV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          reload,
    input  logic          step,
    input  logic          par_mode,
    input  logic [RW-1:0] rev_sel,
    output logic [AW-1:0] addr,
    output logic [2:0]    bit_idx,
    output logic [RW-1:0] rev_q,
    output seq_state_e    state
);
    seq_state_e    st_n;
    logic [AW-1:0] addr_n;
    logic [2:0]    bit_n;
    logic [RW-1:0] rev_n;
    logic [AW-1:0] base_n;
    logic [AW-1:0] last_a;

    function automatic logic [AW-1:0] base_of(input logic [RW-1:0] r);
        return REV_BASE[int'(r)*AW +: AW];
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            addr    <= base_of('0);
            bit_idx <= '0;
            rev_q   <= '0;
        end else begin
            state   <= st_n;
            addr    <= addr_n;
            bit_idx <= bit_n;
            rev_q   <= rev_n;
        end
    end

    // next-state and counter rules
    always_comb begin
        rev_n  = reload ? rev_sel : rev_q;
        base_n = base_of(rev_n);
        last_a = base_of(rev_q) + AW'(SPAN - 1);
        st_n   = state;
        addr_n = addr;
        bit_n  = bit_idx;
        if (hold) begin
            st_n   = ST_HOLD;
            addr_n = base_n;
            bit_n  = '0;
        end else if (reload) begin
            st_n   = ST_RUN;
            addr_n = base_n;
            bit_n  = '0;
        end else begin
            unique case (state)
                ST_HOLD: st_n = ST_RUN;
                ST_RUN: begin
                    if (step) begin
                        if (par_mode || bit_idx == 3'd7) begin
                            if (addr == last_a) begin
                                st_n = ST_DONE;
                            end else begin
                                addr_n = addr + AW'(1);
                                bit_n  = '0;
                            end
                        end else begin
                            bit_n = bit_idx + 3'd1;
                        end
                    end
                end
                ST_DONE: st_n = ST_DONE;
                default: st_n = ST_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/cfg_outstage.sv
module cfg_outstage
    import cfg_readout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              par_mode,
    input  seq_state_e        state,
    input  logic [BYTE_W-1:0] rbyte,
    input  logic [2:0]        bit_idx,
    input  logic              clk_lvl,
    output logic [BYTE_W-1:0] dout,
    output logic [BYTE_W-1:0] dout_oe,
    output logic              clkout,
    output logic              clkout_oe,
    output logic              done
);
    logic [2:0] bit_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_d     <= '0;
            dout      <= '0;
            dout_oe   <= '0;
            clkout    <= 1'b0;
            clkout_oe <= 1'b0;
            done      <= 1'b0;
        end else begin
            bit_d     <= bit_idx;
            done      <= (state == ST_DONE) && !hold;
            clkout    <= clk_lvl;
            clkout_oe <= !hold;
            if (hold) begin
                dout    <= '0;
                dout_oe <= '0;
            end else if (par_mode) begin
                dout    <= rbyte;
                dout_oe <= '1;
            end else begin
                dout    <= {{(BYTE_W-1){1'b0}}, rbyte[3'd7 - bit_d]};
                dout_oe <= {{(BYTE_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/cfg_readout.sv
module cfg_readout
    import cfg_readout_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NREV  = 4,
    parameter int SPAN  = 16,
    parameter int SYNC  = 2,
    parameter logic [NREV*$clog2(DEPTH)-1:0] REV_BASE = {6'd48, 6'd32, 6'd16, 6'd0}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_clk,
    input  logic                     int_tick,
    input  logic                     clk_sel_int,
    input  logic                     ce_n,
    input  logic                     oe_rst_n,
    input  logic                     busy,
    input  logic                     cfg_pulse,
    input  logic [$clog2(NREV)-1:0]  rev_sel,
    input  logic                     par_mode,
    output logic [BYTE_W-1:0]        dout,
    output logic [BYTE_W-1:0]        dout_oe,
    output logic                     clkout,
    output logic                     clkout_oe,
    output logic                     done
);
    localparam int AW = $clog2(DEPTH);
    localparam int RW = $clog2(NREV);

    logic              ck_lvl, ck_rise, pl_lvl, reload;
    logic              hold, strobe, step, clk_lvl;
    logic [AW-1:0]     addr_q;
    logic [2:0]        bit_idx;
    logic [RW-1:0]     rev_q;
    logic [BYTE_W-1:0] rbyte;
    seq_state_e        state;

    cfg_edge_sync #(.STAGES(SYNC)) u_ck_sync (
        .clk(clk), .rst_n(rst_n), .din(cfg_clk), .level(ck_lvl), .rise(ck_rise)
    );
    cfg_edge_sync #(.STAGES(SYNC)) u_pl_sync (
        .clk(clk), .rst_n(rst_n), .din(cfg_pulse), .level(pl_lvl), .rise(reload)
    );

    assign hold    = ce_n | ~oe_rst_n;
    assign strobe  = clk_sel_int ? int_tick : ck_rise;
    assign clk_lvl = clk_sel_int ? int_tick : ck_lvl;
    assign step    = strobe & pl_lvl & (~par_mode | ~busy);

    cfg_seq #(
        .AW(AW), .NREV(NREV), .SPAN(SPAN), .REV_BASE(REV_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .hold(hold), .reload(reload), .step(step),
        .par_mode(par_mode), .rev_sel(rev_sel), .addr(addr_q),
        .bit_idx(bit_idx), .rev_q(rev_q), .state(state)
    );

    cfg_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .addr(addr_q), .rdata(rbyte)
    );

    cfg_outstage u_out (
        .clk(clk), .rst_n(rst_n), .hold(hold), .par_mode(par_mode),
        .state(state), .rbyte(rbyte), .bit_idx(bit_idx), .clk_lvl(clk_lvl),
        .dout(dout), .dout_oe(dout_oe), .clkout(clkout),
        .clkout_oe(clkout_oe), .done(done)
    );
endmodule

// File: rtl/cfg_readout_chk.sv
module cfg_readout_chk #(
    parameter int AW   = 6,
    parameter int NREV = 4,
    parameter int SPAN = 16,
    parameter logic [NREV*AW-1:0] REV_BASE = '0,
    localparam int RW  = $clog2(NREV)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_rst_n,
    input logic          busy,
    input logic          par_mode,
    input logic [RW-1:0] rev_sel,
    input logic [7:0]    dout_oe,
    input logic          clkout_oe,
    input logic          done,
    input logic          reload,
    input logic [AW-1:0] addr,
    input logic [RW-1:0] rev_q
);
    function automatic logic [AW-1:0] base_of(input logic [RW-1:0] r);
        return REV_BASE[int'(r)*AW +: AW];
    endfunction

    p_oe_tristate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_rst_n |=> (dout_oe == 8'h00 && !clkout_oe));

    p_standby_tristate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (dout_oe == 8'h00 && !clkout_oe));

    p_busy_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (par_mode && busy && !reload && oe_rst_n && !ce_n) |=> $stable(addr));

    p_reload_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (addr == base_of($past(rev_sel)) && rev_q == $past(rev_sel)));

    p_serial_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !par_mode |=> dout_oe[7:1] == 7'd0);

    p_done_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload && oe_rst_n && !ce_n) |=> ($stable(addr)));

    p_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= base_of(rev_q) && addr <= base_of(rev_q) + AW'(SPAN - 1)));
endmodule

bind cfg_readout cfg_readout_chk #(
    .AW(AW), .NREV(NREV), .SPAN(SPAN), .REV_BASE(REV_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .busy(busy),
    .par_mode(par_mode), .rev_sel(rev_sel), .dout_oe(dout_oe),
    .clkout_oe(clkout_oe), .done(done), .reload(reload), .addr(addr_q),
    .rev_q(rev_q)
);

// File: tb/tb_cfg_readout.sv
module tb_cfg_readout;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_clk = 1'b0, int_tick = 1'b0, clk_sel_int = 1'b0;
    logic       ce_n = 1'b1, oe_rst_n = 1'b1, busy = 1'b0, cfg_pulse = 1'b0;
    logic [1:0] rev_sel = 2'd0;
    logic       par_mode = 1'b1;
    logic [7:0] dout, dout_oe;
    logic       clkout, clkout_oe, done;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_readout dut (
        .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .int_tick(int_tick),
        .clk_sel_int(clk_sel_int), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
        .busy(busy), .cfg_pulse(cfg_pulse), .rev_sel(rev_sel),
        .par_mode(par_mode), .dout(dout), .dout_oe(dout_oe),
        .clkout(clkout), .clkout_oe(clkout_oe), .done(done)
    );

    // vector: {rev[1:0], steps[9:0]}
    localparam logic [11:0] VEC [7] = '{
        {2'd0, 10'd0}, {2'd0, 10'd3}, {2'd2, 10'd5}, {2'd3, 10'd1},
        {2'd1, 10'd15}, {2'd1, 10'd16}, {2'd3, 10'd20}
    };

    function automatic logic [7:0] exp_byte(input int a);
        int v;
        v = (a * 29) ^ 'h5A;
        return v[7:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_ext(input int n);
        for (int i = 0; i < n; i++) begin
            cfg_clk = 1'b1; wait_n(4);
            cfg_clk = 1'b0; wait_n(4);
        end
    endtask

    task automatic do_reload(input int r);
        cfg_pulse = 1'b0; wait_n(4);
        rev_sel = 2'(r);
        cfg_pulse = 1'b1; wait_n(6);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", total, fails);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] b;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(3);
        // R10 reset state, standby outputs off
        chk("R10 dout_oe after reset", dout_oe, 8'h00);
        chk("R10 done after reset", done, 0);
        chk("R3 clkout_oe in standby", clkout_oe, 0);

        ce_n = 1'b0;
        cfg_pulse = 1'b1;
        wait_n(6);
        chk("R6 parallel enables", dout_oe, 8'hFF);
        chk("R9 first byte rev0", dout, exp_byte(0));

        // table walk, parallel mode (R6, R7, R9, R4)
        for (int v = 0; v < 7; v++) begin
            int r, n, a;
            r = int'(VEC[v][11:10]);
            n = int'(VEC[v][9:0]);
            do_reload(r);
            step_ext(n);
            a = r * 16 + ((n > 15) ? 15 : n);
            chk($sformatf("R6 vec%0d byte", v), dout, exp_byte(a));
            chk($sformatf("R7 vec%0d done", v), done, (n > 15) ? 1 : 0);
        end
        // R7: reload clears done
        do_reload(0);
        chk("R7 done cleared by reload", done, 0);

        // R1: busy blocks parallel steps
        busy = 1'b1;
        step_ext(3);
        chk("R1 busy freezes counter", dout, exp_byte(0));
        busy = 1'b0;
        step_ext(1);
        chk("R1 step after busy", dout, exp_byte(1));

        // R1: cfg_pulse low blocks steps
        cfg_pulse = 1'b0; wait_n(4);
        step_ext(2);
        chk("R1 pulse low freezes", dout, exp_byte(1));

        // R4: reload wins over simultaneous step
        rev_sel = 2'd2;
        cfg_pulse = 1'b1; cfg_clk = 1'b1; wait_n(4);
        cfg_clk = 1'b0; wait_n(4);
        chk("R4 reload priority", dout, exp_byte(32));
        step_ext(2);

        // R2: output-enable/reset low
        oe_rst_n = 1'b0; wait_n(3);
        chk("R2 dout_oe off", dout_oe, 8'h00);
        chk("R2 clkout_oe off", clkout_oe, 0);
        chk("R2 dout zero", dout, 0);
        oe_rst_n = 1'b1; wait_n(4);
        chk("R2 counter rewound", dout, exp_byte(32));

        // R3: standby ignores steps and rewinds
        step_ext(3);
        ce_n = 1'b1; wait_n(2);
        step_ext(2);
        chk("R3 standby outputs off", dout_oe, 8'h00);
        ce_n = 1'b0; wait_n(4);
        chk("R3 counter rewound", dout, exp_byte(32));

        // R5: serial mode, MSB first, busy ignored
        par_mode = 1'b0;
        busy = 1'b1;
        do_reload(2);
        chk("R5 serial enables", dout_oe, 8'h01);
        b = exp_byte(32);
        for (int k = 0; k < 8; k++) begin
            chk($sformatf("R5 serial bit %0d", k), dout, {7'd0, b[7-k]});
            step_ext(1);
        end
        b = exp_byte(33);
        chk("R5 next byte MSB", dout, {7'd0, b[7]});
        busy = 1'b0;
        par_mode = 1'b1;

        // R8: internal clock source
        clk_sel_int = 1'b1;
        do_reload(0);
        step_ext(2);
        chk("R8 cfg_clk ignored", dout, exp_byte(0));
        for (int t = 0; t < 3; t++) begin
            int_tick = 1'b1; wait_n(1);
            int_tick = 1'b0; wait_n(3);
        end
        wait_n(2);
        chk("R8 int_tick steps", dout, exp_byte(3));
        clk_sel_int = 1'b0;
        cfg_clk = 1'b1; wait_n(5);
        chk("R8 clkout follows cfg_clk", clkout, 1);
        cfg_clk = 1'b0; wait_n(5);
        chk("R8 clkout low", clkout, 0);

        summary();
        $finish;
    end
endmodule